// File: doc/BRIEF.md
# Interleaved Symmetric FIR Datapath

This block is a single-channel horizontal FIR filter with sixteen taps, folded into eight mirrored tap pairs. One sample enters on every clock. The sample ripples through fifteen delay stages. Each stage delays by a programmable length L of 1 to 16 cycles. With that length, the filter can work on L data sets that are interleaved sample by sample in one stream, with no need to split them apart. With the same setting, it can also be decimated by L. Tap k therefore carries the input sample from k*L cycles ago.

For each mirrored pair, a pre-adder combines the two taps. The pre-adder can form the sum, the difference, or pass a single operand, which covers even-symmetric, odd-symmetric and asymmetric coefficient sets. Each pre-adder result is multiplied by one of eight programmable coefficients, and the eight products are summed into a registered output. An odd-tap mode shortens the filter to fifteen taps, with an unpaired centre tap.

A free-running modulo-L counter raises an output strobe on every Lth result. Downstream logic keeps only the strobed results when decimating. Any configuration write restarts this counter.

Top module: `ilv_fir16`

## Requirements
- R1: While reset is asserted, and directly after it is released, `dout` is 0 and `dout_stb` is 0. The configuration comes up as L = 1, sum mode, no operand zeroed, even-tap mode, and all coefficients 0.
- R2: In even-tap mode with `cfg_alu` = 3'b000, the output is the sum over i = 0..7 of c_i * (t_i + t_(15-i)), where t_k is the input sample from k*L cycles before the current one.
- R3: `cfg_alu[0]` = 1 changes each pair term to c_i * (t_(15-i) - t_i), which is B minus A with A = t_i.
- R4: `cfg_alu[1]` = 1 replaces the A operand (t_i) by zero, and `cfg_alu[2]` = 1 replaces the B operand by zero. With both bits set, every pair contributes zero.
- R5: The delay length is L = `cfg_len` + 1. So 4'b0000 selects one cycle per stage and 4'b1111 selects sixteen cycles per stage.
- R6: With `cfg_odd` = 1, pairs i = 0..6 combine t_i with t_(14-i). The centre term is c_7 * t_7, and it is not affected by `cfg_alu`.
- R7: A coefficient write with `coef_addr` = i loads c_i. The new value is first used for the output produced one edge after the write edge.
- R8: The strobe is high on every Lth output. A configuration write restarts the count, so the first strobe after the write comes L outputs later. If the write lands in the same cycle as a strobe boundary, that strobe is suppressed.
- R9: `dout` updates on the clock edge that captures the current `din`, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Loads `cfg_alu`, `cfg_odd` and `cfg_len`, and restarts the strobe counter |
| cfg_alu | input | 3 | Bit 0 selects B-A, bit 1 zeroes A, bit 2 zeroes B |
| cfg_odd | input | 1 | Odd-tap mode with an unpaired centre tap |
| cfg_len | input | 4 | Delay length minus one |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Index of the pair whose coefficient is written |
| coef_data | input | 10 | Signed coefficient value |
| din | input | 10 | Signed input sample, one per clock |
| dout | output | 26 | Signed filter result |
| dout_stb | output | 1 | High on every Lth result |

## Verification
A configuration write can arrive in the same cycle as the strobe counter reaching its last count. In that case the restart must win, and the strobe that would have marked that boundary must not appear. The bench writes an unchanged length at many different spacings (every fifth cycle and every seventh cycle, with L = 4 and then L = 3). This lands writes on every counter phase, including the final one. A reference counter in the bench predicts each strobe cycle by cycle, and every output is compared against it. Data results are compared against a history-based reference in the same cycles, so a write that hits a boundary is also shown not to disturb the samples.

// File: rtl/ilv_fir_pkg.sv
package ilv_fir_pkg;
  localparam int FIR_DATA_W = 10;
  localparam int FIR_COEF_W = 10;
  localparam int FIR_LEN_W  = 4;
  localparam int FIR_PAIRS  = 8;
  localparam int FIR_ACC_W  = 26;

  // bit positions inside the ALU control field
  localparam int ALU_SUB_BIT = 0;
  localparam int ALU_ZA_BIT  = 1;
  localparam int ALU_ZB_BIT  = 2;

  typedef enum logic {
    ALU_SUM  = 1'b0,
    ALU_DIFF = 1'b1
  } alu_op_e;
endpackage

// File: rtl/ilv_delay_stage.sv
module ilv_delay_stage #(
  parameter int DATA_W = 10,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << LEN_W;

  logic [DEPTH-1:0][DATA_W-1:0] sh_q;
  logic [DEPTH-1:0][DATA_W-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  // element j holds the input from j+1 cycles ago
  assign dout = sh_q[len_m1];

  AST_SINGLE_CYCLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (len_m1 == '0 && $past(rst_n)) |-> dout == $past(din)); // R5
endmodule

// File: rtl/ilv_preadd.sv
module ilv_preadd #(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              op_sub,
  input  logic              zero_a,
  input  logic              zero_b,
  output logic [DATA_W:0]   res
);
  logic signed [DATA_W:0] ax;
  logic signed [DATA_W:0] bx;

  always_comb begin
    ax  = zero_a ? '0 : {a[DATA_W-1], a};
    bx  = zero_b ? '0 : {b[DATA_W-1], b};
    res = op_sub ? (bx - ax) : (ax + bx);
  end

  always_comb begin
    if (zero_a && zero_b) begin
      AST_BOTH_GATED_ZERO: assert (res == '0); // R4
    end
  end
endmodule

// File: rtl/ilv_dec_strobe.sv
module ilv_dec_strobe #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [LEN_W-1:0] len_m1,
  output logic             stb
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_nxt;
  logic             stb_q;
  logic             stb_nxt;
  logic             wrap;

  always_comb begin
    wrap    = (cnt_q == len_m1);
    stb_nxt = wrap && !restart;
    if (restart)   cnt_nxt = '0;
    else if (wrap) cnt_nxt = '0;
    else           cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      stb_q <= stb_nxt;
    end
  end

  assign stb = stb_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_m1); // R8
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0); // R8
endmodule

// File: rtl/ilv_fir16.sv
module ilv_fir16
  import ilv_fir_pkg::*;
#(
  parameter int DATA_W    = FIR_DATA_W,
  parameter int COEF_W    = FIR_COEF_W,
  parameter int LEN_W     = FIR_LEN_W,
  parameter int NUM_PAIRS = FIR_PAIRS,
  parameter int ACC_W     = FIR_ACC_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [2:0]                   cfg_alu,
  input  logic                         cfg_odd,
  input  logic [LEN_W-1:0]             cfg_len,
  input  logic                         coef_we,
  input  logic [$clog2(NUM_PAIRS)-1:0] coef_addr,
  input  logic [COEF_W-1:0]            coef_data,
  input  logic [DATA_W-1:0]            din,
  output logic [ACC_W-1:0]             dout,
  output logic                         dout_stb
);
  localparam int NUM_TAPS = 2 * NUM_PAIRS;
  localparam int PRE_W    = DATA_W + 1;

  // configuration state
  alu_op_e          alu_op_q, alu_op_nxt;
  logic             zero_a_q, zero_a_nxt;
  logic             zero_b_q, zero_b_nxt;
  logic             odd_q, odd_nxt;
  logic [LEN_W-1:0] len_m1_q, len_m1_nxt;

  logic [NUM_PAIRS-1:0][COEF_W-1:0] coef_q;
  logic [NUM_PAIRS-1:0][COEF_W-1:0] coef_nxt;

  logic [NUM_TAPS-1:0][DATA_W-1:0] tap;
  logic [NUM_PAIRS-1:0][PRE_W-1:0] pre;

  logic signed [ACC_W-1:0] acc_nxt;
  logic [ACC_W-1:0]        dout_q;

  always_comb begin
    alu_op_nxt = alu_op_q;
    zero_a_nxt = zero_a_q;
    zero_b_nxt = zero_b_q;
    odd_nxt    = odd_q;
    len_m1_nxt = len_m1_q;
    if (cfg_we) begin
      alu_op_nxt = cfg_alu[ALU_SUB_BIT] ? ALU_DIFF : ALU_SUM;
      zero_a_nxt = cfg_alu[ALU_ZA_BIT];
      zero_b_nxt = cfg_alu[ALU_ZB_BIT];
      odd_nxt    = cfg_odd;
      len_m1_nxt = cfg_len;
    end
  end

  always_comb begin
    coef_nxt = coef_q;
    if (coef_we) coef_nxt[coef_addr] = coef_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alu_op_q <= ALU_SUM;
      zero_a_q <= 1'b0;
      zero_b_q <= 1'b0;
      odd_q    <= 1'b0;
      len_m1_q <= '0;
      coef_q   <= '0;
    end else begin
      alu_op_q <= alu_op_nxt;
      zero_a_q <= zero_a_nxt;
      zero_b_q <= zero_b_nxt;
      odd_q    <= odd_nxt;
      len_m1_q <= len_m1_nxt;
      coef_q   <= coef_nxt;
    end
  end

  // tapped delay line: tap k is the sample from k*L cycles ago
  assign tap[0] = din;
  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_stage
    ilv_delay_stage #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .len_m1 (len_m1_q),
      .din    (tap[k-1]),
      .dout   (tap[k])
    );
  end

  // pre-adders on mirrored pairs
  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    logic [DATA_W-1:0] b_src;
    logic              op_i, za_i, zb_i;
    if (i == NUM_PAIRS - 1) begin : g_centre
      // odd-tap mode: the centre tap passes alone
      always_comb begin
        b_src = odd_q ? '0 : tap[NUM_TAPS-1-i];
        op_i  = odd_q ? 1'b0 : (alu_op_q == ALU_DIFF);
        za_i  = odd_q ? 1'b0 : zero_a_q;
        zb_i  = odd_q ? 1'b1 : zero_b_q;
      end
    end else begin : g_outer
      always_comb begin
        b_src = odd_q ? tap[NUM_TAPS-2-i] : tap[NUM_TAPS-1-i];
        op_i  = (alu_op_q == ALU_DIFF);
        za_i  = zero_a_q;
        zb_i  = zero_b_q;
      end
    end
    ilv_preadd #(.DATA_W(DATA_W)) u_alu (
      .a      (tap[i]),
      .b      (b_src),
      .op_sub (op_i),
      .zero_a (za_i),
      .zero_b (zb_i),
      .res    (pre[i])
    );
  end

  always_comb begin
    acc_nxt = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      acc_nxt = acc_nxt + ACC_W'($signed(pre[i])) * ACC_W'($signed(coef_q[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= acc_nxt;
  end

  assign dout = dout_q;

  ilv_dec_strobe #(.LEN_W(LEN_W)) u_stb (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_we),
    .len_m1  (len_m1_q),
    .stb     (dout_stb)
  );

  AST_ZERO_COEF_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_q == '0) |=> dout == '0); // R7
  AST_LEN1_STB_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (len_m1_q == '0 && !cfg_we) |=> dout_stb); // R8
  AST_RESTART_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && len_m1_q != '0) |=> !dout_stb); // R8
endmodule

// File: tb/ilv_fir16_tb_top.sv
module ilv_fir16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_alu;
  logic        cfg_odd;
  logic [3:0]  cfg_len;
  logic        coef_we;
  logic [2:0]  coef_addr;
  logic [9:0]  coef_data;
  logic [9:0]  din;
  logic [25:0] dout;
  logic        dout_stb;

  always #2 clk = ~clk;

  ilv_fir16 dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_alu(cfg_alu), .cfg_odd(cfg_odd),
    .cfg_len(cfg_len), .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .din(din), .dout(dout), .dout_stb(dout_stb)
  );

  typedef struct {
    int    dout;
    bit    stb;
    bit    chk;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  string cur_tag = "R2";

  // reference model state
  int hist[512];
  int n = 512;
  int m_alu = 0, m_odd = 0, m_len = 1, mcnt = 0, settle = 1000;
  int m_coef[8];

  // pending writes applied on the next step
  bit p_we = 0, p_cwe = 0;
  int p_alu = 0, p_odd = 0, p_len = 0, p_caddr = 0, p_cdata = 0;

  function automatic int tapv(int k);
    return hist[(n - k * m_len) % 512];
  endfunction

  function automatic int model_out();
    int s = 0;
    for (int i = 0; i < 8; i++) begin
      int a, b, p;
      if (m_odd != 0 && i == 7) p = tapv(7);
      else begin
        a = tapv(i);
        b = (m_odd != 0) ? tapv(14 - i) : tapv(15 - i);
        if (m_alu[1]) a = 0;
        if (m_alu[2]) b = 0;
        p = m_alu[0] ? (b - a) : (a + b);
      end
      s += p * m_coef[i];
    end
    return s;
  endfunction

  task automatic step(input int x);
    exp_t e;
    @(negedge clk);
    din       = 10'(x);
    cfg_we    = p_we;
    cfg_alu   = 3'(p_alu);
    cfg_odd   = p_odd[0];
    cfg_len   = 4'(p_len);
    coef_we   = p_cwe;
    coef_addr = 3'(p_caddr);
    coef_data = 10'(p_cdata);
    n++;
    hist[n % 512] = x;
    e.dout = model_out();
    e.chk  = (settle >= 16 * m_len);
    e.stb  = !p_we && (mcnt == m_len - 1);
    e.tag  = cur_tag;
    q.push_back(e);
    if (p_we) begin
      mcnt = 0;
      if (p_len + 1 != m_len) settle = 0;
      m_alu = p_alu; m_odd = p_odd; m_len = p_len + 1;
    end else begin
      mcnt = (mcnt == m_len - 1) ? 0 : mcnt + 1;
    end
    settle++;
    if (p_cwe) m_coef[p_caddr] = p_cdata;
    p_we = 0;
    p_cwe = 0;
  endtask

  task automatic set_cfg(input int alu, input int odd, input int len_m1);
    p_we = 1; p_alu = alu; p_odd = odd; p_len = len_m1;
  endtask

  task automatic set_coef(input int addr, input int val);
    p_cwe = 1; p_caddr = addr; p_cdata = val;
  endtask

  task automatic run(input int count);
    for (int i = 0; i < count; i++) begin
      logic [9:0] rv;
      rv = 10'($urandom);
      if (i % 9 == 4) rv = 10'h1FF;
      else if (i % 9 == 8) rv = 10'h200;
      step(int'($signed(rv)));
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk) begin
          checks++;
          if (int'($signed(dout)) != e.dout) begin
            failures++;
            $display("FAIL %s dout actual=%0d expected=%0d", e.tag, int'($signed(dout)), e.dout);
          end
        end
        checks++;
        if (dout_stb !== e.stb) begin
          failures++;
          $display("FAIL R8 dout_stb actual=%0b expected=%0b", dout_stb, e.stb);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check_reset();
    checks++;
    if (dout !== 26'd0 || dout_stb !== 1'b0) begin
      failures++;
      $display("FAIL R1 dout/stb actual=%0d/%0b expected=0/0", dout, dout_stb);
    end
  endtask

  initial begin
    int coefs[8] = '{3, -5, 7, 11, -13, 17, -19, 23};
    for (int i = 0; i < 512; i++) hist[i] = 0;
    for (int i = 0; i < 8; i++) m_coef[i] = 0;
    rst_n = 1'b0; cfg_we = 0; cfg_alu = 0; cfg_odd = 0; cfg_len = 0;
    coef_we = 0; coef_addr = 0; coef_data = 0; din = 0;
    repeat (4) @(posedge clk);
    #1 check_reset();                         // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    #1 check_reset();                         // R1 after release

    cur_tag = "R7";                           // coefficient loading
    for (int i = 0; i < 8; i++) begin
      set_coef(i, coefs[i]);
      step(0);
    end

    cur_tag = "R9";                           // impulse response, one-cycle latency
    step(100);
    for (int i = 0; i < 20; i++) step(0);

    cur_tag = "R2";  run(40);
    cur_tag = "R3";  set_cfg(1, 0, 0); run(40);
    cur_tag = "R4";  set_cfg(2, 0, 0); run(30);
    set_cfg(4, 0, 0); run(30);
    set_cfg(6, 0, 0); run(30);
    set_cfg(3, 0, 0); run(30);
    cur_tag = "R5";  set_cfg(0, 0, 1);  run(80);
    set_cfg(0, 0, 15); run(320);
    set_cfg(1, 0, 0);  run(40);
    cur_tag = "R6";  set_cfg(0, 1, 0);  run(40);
    set_cfg(5, 1, 1);  run(80);
    cur_tag = "R7";  set_cfg(0, 0, 0);
    for (int i = 0; i < 40; i++) begin
      if (i % 5 == 2) set_coef(i % 8, int'($signed(10'($urandom))));
      run(1);
    end
    cur_tag = "R8";  set_cfg(0, 0, 3);
    for (int i = 0; i < 120; i++) begin
      if (i == 60) set_cfg(1, 0, 2);
      else if (i % 5 == 3 || i % 7 == 0) set_cfg(i < 60 ? 0 : 1, 0, i < 60 ? 3 : 2);
      run(1);
    end
    run(20);

    repeat (3) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule